// File: doc/BRIEF.md
# Dual-Color LED Matrix Scan Controller

This block refreshes a chain of dual-color dot-matrix panels that are multiplexed one row in sixteen. Each panel row has 32 dots per color. For one row at a time, the controller reads two bits per pixel (red and green) from a frame-buffer read port. It shifts the red and green bits out in lockstep on two serial lines with a generated shift clock. The bit for the far end of the panel chain goes out first. While the previous row stays lit, the next row's bits are shifted in behind it.

After the last bit, the controller runs a fixed handover, with one full shift-clock period between steps:
1. Raise the blanking line.
2. Move the 4-bit row address.
3. Pulse the level-transparent latch strobe high and then low.
4. Release blanking.

Each row takes a fixed number of half-period ticks, so the frame rate is set by parameters. A frame-start pulse makes row 0 the next row to be loaded. The row already in progress is always finished first, so a half-shifted row is never latched.

Top module: `ledscan_ctrl`

## Requirements
- R1: While reset is held and at its release, blank is 1, latch is 0, sclk is 0, sdat_r and sdat_g are 0, and row_addr is 15, so the first row loaded is row 0.
- R2: Each row shifts BITS = 32 × N_PANELS bits on sdat_r and sdat_g together. The bit presented at the k-th rising edge of sclk (k counting from 0) is the frame-buffer bit for column BITS-1-k of the row being loaded. A 1 lights the dot. fb_row gives that row and fb_col gives that column during the shift.
- R3: sclk is high for HALF_DIV clocks and low for HALF_DIV clocks between the bits of a row. sdat_r and sdat_g change only while sclk is low and hold steady while it is high.
- R4: The handover steps occur in this order, each 2 × HALF_DIV clocks after the previous one:
  - sclk returns low after the last bit;
  - blank rises;
  - row_addr takes the new row;
  - latch rises;
  - latch falls;
  - blank falls.
  row_addr changes only while blank has been high for at least one clock.
- R5: latch is high only while blank is high and sclk is low. latch never rises before all BITS bits of the row have been shifted.
- R6: With no frame-start pulse, successive latched rows run 0, 1, …, 15 and then wrap to 0.
- R7: Successive rising edges of latch are exactly max(ROW_TICKS, 2 × BITS + 13) × HALF_DIV clocks apart.
- R8: A frame_start pulse does not disturb the row in progress, which is fully shifted and latched at its own address. The next row loaded and latched is row 0.
- R9: The latch pulse stays high for exactly 2 × HALF_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock pulse that makes row 0 the next row loaded |
| fb_red | input | 1 | Red bit of the pixel at fb_row/fb_col (combinational read) |
| fb_grn | input | 1 | Green bit of the pixel at fb_row/fb_col (combinational read) |
| fb_row | output | 4 | Row whose bits are being shifted |
| fb_col | output | $clog2(32·N_PANELS) | Column whose bits are being fetched |
| sclk | output | 1 | Shift clock; panels shift on its rising edge |
| sdat_r | output | 1 | Serial red data |
| sdat_g | output | 1 | Serial green data |
| latch | output | 1 | Latch strobe; transparent while high, holds when low |
| blank | output | 1 | Blanking; 1 turns every dot off |
| row_addr | output | 4 | Address of the displayed row |

## Verification
The assertions assume the frame-buffer port answers within the same clock. They also assume fb_red and fb_grn depend only on fb_row and fb_col, so data captured at a shift-clock edge matches the addressed pixel. frame_start is taken as a single-clock pulse that may arrive at any point in a row. The bench models the frame buffer as a pure function of row and column. It changes the selected pattern only just after a latch edge, which is long before the next row's shift begins. It pulses frame_start both in the middle of a shift and in the idle part of a row.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;

  localparam int SCAN_ROWS  = 16;
  localparam int ROW_AW     = 4;
  localparam int PANEL_COLS = 32;

  typedef enum logic [2:0] {
    SH_IDLE, SH_LOW, SH_HIGH, SH_TAIL0, SH_TAIL1
  } shift_st_e;

  typedef enum logic [2:0] {
    SQ_WAIT, SQ_SHIFT, SQ_BLANK, SQ_ADDR, SQ_LATHI, SQ_LATLO, SQ_SHOW
  } seq_st_e;

  // Bits per row for a chain of panels.
  function automatic int chain_bits(int panels);
    return PANEL_COLS * panels;
  endfunction

  // The first bit shifted lands at the far end of the chain.
  function automatic int col_of_bit(int bits, int k);
    return bits - 1 - k;
  endfunction

  // Ticks for shift, tail and five handover steps, plus one idle tick.
  function automatic int min_row_ticks(int bits);
    return 2 * bits + 13;
  endfunction

  function automatic int eff_row_ticks(int req, int bits);
    return (req < min_row_ticks(bits)) ? min_row_ticks(bits) : req;
  endfunction

endpackage

// File: rtl/ledscan_tick.sv
module ledscan_tick #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_every
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/ledscan_shifter.sv
module ledscan_shifter
  import ledscan_pkg::*;
#(
  parameter int BITS = 32,
  localparam int IW  = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          fb_red,
  input  logic          fb_grn,
  output logic [IW-1:0] bit_idx,
  output logic          sclk,
  output logic          sdat_r,
  output logic          sdat_g,
  output logic          busy,
  output logic          done
);

  shift_st_e st;
  logic      last_bit;

  assign last_bit = (bit_idx == IW'(BITS - 1));
  assign busy     = (st != SH_IDLE);
  assign done     = tick && (st == SH_TAIL1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      bit_idx <= '0;
      sclk    <= 1'b0;
      sdat_r  <= 1'b0;
      sdat_g  <= 1'b0;
    end else if (tick) begin
      unique case (st)
        SH_IDLE: begin
          if (start) begin
            st      <= SH_LOW;
            bit_idx <= '0;
          end
        end
        SH_LOW: begin
          sclk   <= 1'b0;
          sdat_r <= fb_red;
          sdat_g <= fb_grn;
          st     <= SH_HIGH;
        end
        SH_HIGH: begin
          sclk <= 1'b1;
          if (last_bit) begin
            st <= SH_TAIL0;
          end else begin
            bit_idx <= bit_idx + IW'(1);
            st      <= SH_LOW;
          end
        end
        SH_TAIL0: begin
          sclk <= 1'b0;
          st   <= SH_TAIL1;
        end
        SH_TAIL1: st <= SH_IDLE;
        default:  st <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ledscan_seq.sv
module ledscan_seq
  import ledscan_pkg::*;
#(
  parameter int ROW_T = 625,
  localparam int RTW  = $clog2(ROW_T)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frame_start,
  input  logic              shift_done,
  output logic              row_go,
  output logic [ROW_AW-1:0] row_sel,
  output logic              blank,
  output logic              latch,
  output logic [ROW_AW-1:0] row_addr
);

  seq_st_e        st;
  logic           ph;
  logic           restart_pend;
  logic [RTW-1:0] rt;

  assign row_go = tick && (st == SQ_WAIT) && (rt == RTW'(ROW_T - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) restart_pend <= 1'b1;
    else        restart_pend <= frame_start | (restart_pend & ~row_go);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_WAIT;
      ph       <= 1'b0;
      rt       <= RTW'(ROW_T - 1);
      blank    <= 1'b1;
      latch    <= 1'b0;
      row_addr <= {ROW_AW{1'b1}};
      row_sel  <= '0;
    end else if (tick) begin
      rt <= row_go ? '0 : rt + RTW'(1);
      unique case (st)
        SQ_WAIT: begin
          if (row_go) begin
            row_sel <= restart_pend ? '0 : row_addr + ROW_AW'(1);
            st      <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: if (shift_done) st <= SQ_BLANK;
        SQ_BLANK: begin
          if (!ph) begin blank <= 1'b1; ph <= 1'b1; end
          else     begin ph <= 1'b0; st <= SQ_ADDR; end
        end
        SQ_ADDR: begin
          if (!ph) begin row_addr <= row_sel; ph <= 1'b1; end
          else     begin ph <= 1'b0; st <= SQ_LATHI; end
        end
        SQ_LATHI: begin
          if (!ph) begin latch <= 1'b1; ph <= 1'b1; end
          else     begin ph <= 1'b0; st <= SQ_LATLO; end
        end
        SQ_LATLO: begin
          if (!ph) begin latch <= 1'b0; ph <= 1'b1; end
          else     begin ph <= 1'b0; st <= SQ_SHOW; end
        end
        SQ_SHOW: begin
          if (!ph) begin blank <= 1'b0; ph <= 1'b1; end
          else     begin ph <= 1'b0; st <= SQ_WAIT; end
        end
        default: st <= SQ_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/ledscan_ctrl.sv
module ledscan_ctrl
  import ledscan_pkg::*;
#(
  parameter int N_PANELS  = 1,
  parameter int HALF_DIV  = 25,
  parameter int ROW_TICKS = 625,
  localparam int BITS     = chain_bits(N_PANELS),
  localparam int COLW     = $clog2(BITS),
  localparam int ROW_T    = eff_row_ticks(ROW_TICKS, BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            fb_red,
  input  logic            fb_grn,
  output logic [3:0]      fb_row,
  output logic [COLW-1:0] fb_col,
  output logic            sclk,
  output logic            sdat_r,
  output logic            sdat_g,
  output logic            latch,
  output logic            blank,
  output logic [3:0]      row_addr
);

  // Named internal events, watched by the bound checker.
  logic            tick_w;
  logic            row_go_w;
  logic            shift_done_w;
  logic            shift_busy_w;
  logic [COLW-1:0] bit_idx_w;
  logic [3:0]      row_sel_w;

  ledscan_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w)
  );

  ledscan_shifter #(.BITS(BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .start  (row_go_w),
    .fb_red (fb_red),
    .fb_grn (fb_grn),
    .bit_idx(bit_idx_w),
    .sclk   (sclk),
    .sdat_r (sdat_r),
    .sdat_g (sdat_g),
    .busy   (shift_busy_w),
    .done   (shift_done_w)
  );

  ledscan_seq #(.ROW_T(ROW_T)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .frame_start(frame_start),
    .shift_done (shift_done_w),
    .row_go     (row_go_w),
    .row_sel    (row_sel_w),
    .blank      (blank),
    .latch      (latch),
    .row_addr   (row_addr)
  );

  assign fb_row = row_sel_w;
  assign fb_col = COLW'(col_of_bit(BITS, int'(bit_idx_w)));

endmodule

// File: rtl/ledscan_chk.sv
module ledscan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       shift_busy,
  input logic       sclk,
  input logic       sdat_r,
  input logic       sdat_g,
  input logic       latch,
  input logic       blank,
  input logic [3:0] row_addr
);

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(tick)); // R3

  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdat_r) || !$stable(sdat_g)) |-> !sclk); // R3

  AST_ADDR_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (blank && $past(blank))); // R4

  AST_UNBLANK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> (!latch && !shift_busy)); // R4

  AST_LATCH_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (blank && !sclk)); // R5

  AST_NO_PARTIAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> !shift_busy); // R5

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == 4'($past(row_addr) + 4'd1) || row_addr == 4'd0)); // R6

endmodule

bind ledscan_ctrl ledscan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .shift_busy(shift_busy_w),
  .sclk      (sclk),
  .sdat_r    (sdat_r),
  .sdat_g    (sdat_g),
  .latch     (latch),
  .blank     (blank),
  .row_addr  (row_addr)
);

// File: tb/tb_ledscan_ctrl.sv
module tb_ledscan_ctrl;
  localparam int NP   = 2;
  localparam int HD   = 2;
  localparam int RT   = 150;
  localparam int BITS = 64;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic fb_red, fb_grn;
  logic [3:0] fb_row;
  logic [CW-1:0] fb_col;
  logic sclk, sdat_r, sdat_g, latch, blank;
  logic [3:0] row_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int pat_sel = 0;
  int exp_row = 0;

  always #10 clk = ~clk;

  ledscan_ctrl #(.N_PANELS(NP), .HALF_DIV(HD), .ROW_TICKS(RT)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .fb_red(fb_red), .fb_grn(fb_grn), .fb_row(fb_row), .fb_col(fb_col),
    .sclk(sclk), .sdat_r(sdat_r), .sdat_g(sdat_g),
    .latch(latch), .blank(blank), .row_addr(row_addr)
  );

  function automatic logic pat(int sel, int row, int col, int color);
    case (sel)
      0:       return (color == 0);
      1:       return ((row + col) % 2) == color;
      default: return (color == 0) ? (((col * 7 + row * 3) % 5) == 0)
                                   : (((col * 3 + row * 5) % 4) == 1);
    endcase
  endfunction

  assign fb_red = pat(pat_sel, int'(fb_row), int'(fb_col), 0);
  assign fb_grn = pat(pat_sel, int'(fb_row), int'(fb_col), 1);

  // Port monitor, sampled on the falling clock edge.
  int cyc = 0, nbits = 0, rise_cyc = 0, fall_cyc = 0;
  int sclk_err = 0, dstab_err = 0;
  int blank_rise_cyc = 0, tail_gap = 0, addr_at_blank = 0;
  int lat_rise_cyc = 0, lat_fall_cyc = 0, prev_lat = 0, lat_count = 0;
  int lat_row = 0, lat_nbits = 0, lat_blank = 0, lat_bit_err = 0;
  int lat_period = -1, pre_gap = 0, lat_w = 0, unblank_gap = 0, unblank_count = 0;
  logic p_sclk = 1'b0, p_latch = 1'b0, p_blank = 1'b1, p_r = 1'b0, p_g = 1'b0;
  logic cap_r [BITS];
  logic cap_g [BITS];

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        if (nbits > 0 && (cyc - fall_cyc) != HD) sclk_err++;
        if (nbits < BITS) begin cap_r[nbits] = sdat_r; cap_g[nbits] = sdat_g; end
        nbits++;
        rise_cyc = cyc;
      end
      if (!sclk && p_sclk) begin
        if ((cyc - rise_cyc) != HD) sclk_err++;
        fall_cyc = cyc;
      end
      if (sclk && p_sclk && (sdat_r !== p_r || sdat_g !== p_g)) dstab_err++;
      if (blank && !p_blank) begin
        blank_rise_cyc = cyc;
        tail_gap = cyc - fall_cyc;
        addr_at_blank = int'(row_addr);
      end
      if (latch && !p_latch) begin
        lat_bit_err = 0;
        for (int k = 0; k < BITS; k++) begin
          if (cap_r[k] !== pat(pat_sel, int'(row_addr), BITS - 1 - k, 0)) lat_bit_err++;
          if (cap_g[k] !== pat(pat_sel, int'(row_addr), BITS - 1 - k, 1)) lat_bit_err++;
        end
        lat_row    = int'(row_addr);
        lat_nbits  = nbits;
        lat_blank  = int'(blank);
        lat_period = (prev_lat > 0) ? cyc - prev_lat : -1;
        pre_gap    = cyc - blank_rise_cyc;
        prev_lat   = cyc;
        lat_rise_cyc = cyc;
        nbits = 0;
        lat_count++;
      end
      if (!latch && p_latch) begin
        lat_w = cyc - lat_rise_cyc;
        lat_fall_cyc = cyc;
      end
      if (!blank && p_blank) begin
        unblank_gap = cyc - lat_fall_cyc;
        unblank_count++;
      end
    end
    p_sclk = sclk; p_latch = latch; p_blank = blank; p_r = sdat_r; p_g = sdat_g;
    cyc++;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_latch();
    int n = lat_count;
    while (lat_count == n) @(posedge clk);
  endtask

  task automatic wait_unblank();
    int n = unblank_count;
    while (unblank_count == n) @(posedge clk);
  endtask

  task automatic pulse_frame_start();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 blank", int'(blank), 1);
    check_eq("R1 latch", int'(latch), 0);
    check_eq("R1 sclk", int'(sclk), 0);
    check_eq("R1 data", int'({sdat_r, sdat_g}), 0);
    check_eq("R1 row_addr", int'(row_addr), 15);
  endtask

  task automatic t_rows(input int sel, input int n);
    pat_sel = sel;
    for (int i = 0; i < n; i++) begin
      wait_latch();
      check_eq("R2 row bits", lat_bit_err, 0);
      check_eq("R5 full shift", lat_nbits, BITS);
      check_eq("R5 blank at latch", lat_blank, 1);
      check_eq("R6 row order", lat_row, exp_row);
      exp_row = (lat_row + 1) % 16;
    end
  endtask

  task automatic t_timing(input int n);
    for (int i = 0; i < n; i++) begin
      wait_latch();
      exp_row = (lat_row + 1) % 16;
      check_eq("R7 row period", lat_period, RT * HD);
      check_eq("R4 tail to blank", tail_gap, 2 * HD);
      check_eq("R4 blank to latch", pre_gap, 4 * HD);
      check_eq("R4 old address at blank", addr_at_blank, (lat_row + 15) % 16);
      wait_unblank();
      check_eq("R9 latch width", lat_w, 2 * HD);
      check_eq("R4 latch fall to unblank", unblank_gap, 2 * HD);
    end
    check_eq("R3 sclk widths", sclk_err, 0);
    check_eq("R3 data stable while high", dstab_err, 0);
  endtask

  task automatic t_fs_mid();
    while (nbits < 5) @(posedge clk);
    pulse_frame_start();
    wait_latch();
    check_eq("R8 row in progress kept", lat_row, exp_row);
    check_eq("R8 row in progress complete", lat_nbits, BITS);
    check_eq("R8 row in progress bits", lat_bit_err, 0);
    wait_latch();
    check_eq("R8 restart row", lat_row, 0);
    check_eq("R8 restart bits", lat_bit_err, 0);
    exp_row = 1;
  endtask

  task automatic t_fs_idle();
    wait_latch();
    check_eq("R6 before restart", lat_row, exp_row);
    repeat (10) @(posedge clk);
    pulse_frame_start();
    wait_latch();
    check_eq("R8 idle restart row", lat_row, 0);
    check_eq("R7 period kept on restart", lat_period, RT * HD);
    exp_row = 1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pat_sel = 0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_rows(0, 2);
    t_rows(1, 2);
    t_rows(2, 16);
    t_timing(3);
    t_fs_mid();
    t_rows(1, 1);
    t_fs_idle();
    t_rows(2, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule